// File: doc/BRIEF.md
# Fourth-Order Sinc Decimation Filter

This block turns the one-bit output of a delta-sigma modulator into signed 24-bit result words. Each accepted input bit is treated as +1 or -1. Four cascaded accumulators run at the input rate. Every `2**DEC_LOG2` accepted bits, four cascaded first-difference stages run once at the reduced rate. Together they give a (sin x / x)^4 response. The decimation ratio is a power of two set by a parameter. A ratio of 2048 suits an input near 246 kHz with about 120 results per second. A ratio of 16384 suits an input near 225 kHz with about 13.75 results per second.

Two conversion modes are offered. In continuous mode the filter state carries over from one result to the next, and a result appears at every decimation point once the filter has settled. In single-cycle mode the filter produces one settled result and then wipes all of its state, so that each result depends only on the bits of its own conversion. A synchronous clear request also restarts the filter at any time. After any clear, results are withheld until enough bits have arrived to fill the whole impulse response.

Top module: `sinc4_decimator`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid` is 0 and `out_word` is 0.
- R2: Input bit 1 counts as +1 and bit 0 counts as -1. A settled result from an all-ones stream saturates to 24'h7FFFFF. A settled result from an all-zeros stream gives 24'h800000.
- R3: With L = DEC_LOG2, R = 2**L and S = 4L-23, each result word equals `sat24(floor((y + 2**(S-1)) / 2**S))`. If S is zero or less, the word is instead `sat24(y * 2**-S)`. Here y is the sum over k = 0 .. 4R-4 of h[k] times the k-th most recent ±1 sample since the last clear, and h is four unit boxcars of length R convolved together.
- R4: A result is formed once per R accepted samples, counted from the last clear. Cycles with `in_valid` low change no filter state.
- R5: `out_valid` is a one-cycle pulse. It is high in the second cycle after the clock edge that accepts the R-th sample of a decimation period, and `out_word` changes only then.
- R6: After reset or any clear, the first three decimation points give no `out_valid`.
- R7: With `mode_single` = 0, the state is not cleared after a result, and every later decimation point gives a result.
- R8: With `mode_single` = 1, exactly one result is given per 4R accepted samples. All state is then cleared in the cycle that forms the result. A sample accepted at that same edge is the first sample of the next conversion.
- R9: A high `clr_req` clears all filter state, restarts the settling count and cancels a result pending in that cycle. A sample accepted at the same edge becomes the first sample after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_single | input | 1 | 1 = single-cycle conversions, 0 = continuous |
| clr_req | input | 1 | Synchronous filter clear request |
| in_valid | input | 1 | Qualifies `in_bit` for this cycle |
| in_bit | input | 1 | Modulator output bit |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_word | output | 24 | Two's complement result, held between strobes |

## Verification
On every cycle, the bound checker covers the following. No strobe appears unless a decimation point came first and the settling count was full. The settling count is wiped after every single-cycle result and stays full after every continuous result. A clear request blocks the next strobe. Idle input cycles leave the sample phase unchanged. The numeric content of each result can only be shown by the bench's scenarios. These compare the words against an independent convolution with the boxcar-to-the-fourth impulse response. They also check saturation at both ends, conversion boundaries under back-to-back input, and the cancelling of a result whose decimation point coincides with a clear.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;

  // Order of the sinc response: number of accumulator and difference stages
  localparam int SINC_ORDER = 4;

  // Accumulator width: gain is R**ORDER, so ORDER*log2(R) bits of magnitude,
  // one bit for the full-scale value itself and one sign bit.
  function automatic int acc_width(input int dec_log2, input int order);
    return order * dec_log2 + 2;
  endfunction

  // Width of the settling counter (counts decimation points up to ORDER-1)
  function automatic int settle_width(input int order);
    return (order <= 2) ? 1 : $clog2(order);
  endfunction

endpackage

// File: rtl/sinc4_integ.sv
// Input-rate accumulator cascade. A clear in the same cycle as a valid
// sample restarts every stage from zero with that sample folded in.
module sinc4_integ #(
  parameter int ACC_W = 46,
  parameter int ORDER = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    in_valid,
  input  logic                    in_bit,
  output logic signed [ACC_W-1:0] acc_out
);

  logic signed [ACC_W-1:0] acc_q [ORDER];
  logic signed [ACC_W-1:0] base  [ORDER];
  logic signed [ACC_W-1:0] nxt   [ORDER];
  logic signed [ACC_W-1:0] x_val;

  // +1 for a one, -1 (all ones) for a zero
  assign x_val = in_bit ? ACC_W'(1) : '1;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    assign base[s] = clr ? '0 : acc_q[s];

    if (s == 0) begin : g_first
      assign nxt[s] = base[s] + x_val;
    end else begin : g_rest
      assign nxt[s] = base[s] + nxt[s-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[s] <= '0;
      end else if (in_valid) begin
        acc_q[s] <= nxt[s];
      end else if (clr) begin
        acc_q[s] <= '0;
      end
    end
  end

  assign acc_out = acc_q[ORDER-1];

endmodule

// File: rtl/sinc4_comb.sv
// Output-rate first-difference cascade with unit delay per stage.
module sinc4_comb #(
  parameter int ACC_W = 46,
  parameter int ORDER = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    tick,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);

  logic signed [ACC_W-1:0] dly    [ORDER];
  logic signed [ACC_W-1:0] stg_in [ORDER];
  logic signed [ACC_W-1:0] diff   [ORDER];

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stg_in[s] = din;
    end else begin : g_rest
      assign stg_in[s] = diff[s-1];
    end

    assign diff[s] = stg_in[s] - dly[s];

    always_ff @(posedge clk) begin
      if (rst) begin
        dly[s] <= '0;
      end else if (clr) begin
        dly[s] <= '0;
      end else if (tick) begin
        dly[s] <= stg_in[s];
      end
    end
  end

  assign dout = diff[ORDER-1];

endmodule

// File: rtl/sinc4_fmt.sv
// Scales the full-precision result to the output width with round-half-up
// and clamps to the signed output range.
module sinc4_fmt #(
  parameter int ACC_W = 46,
  parameter int OUT_W = 24,
  parameter int SHIFT = 21
) (
  input  logic signed [ACC_W-1:0] din,
  output logic        [OUT_W-1:0] dout
);

  localparam int VW = (SHIFT > 0) ? ACC_W + 1 : OUT_W + 2;
  localparam logic signed [VW-1:0] MAXV = VW'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [VW-1:0] MINV = -MAXV - VW'(1);

  logic signed [VW-1:0] scaled;

  if (SHIFT > 0) begin : g_round
    localparam logic signed [VW-1:0] HALF = VW'(64'sd1 <<< (SHIFT-1));
    logic signed [VW-1:0] ext;
    assign ext    = VW'(din);
    assign scaled = (ext + HALF) >>> SHIFT;
  end else begin : g_widen
    localparam int LSH = -SHIFT;
    logic signed [VW-1:0] ext;
    assign ext    = VW'(din);
    assign scaled = ext <<< LSH;
  end

  always_comb begin
    if (scaled > MAXV) begin
      dout = MAXV[OUT_W-1:0];
    end else if (scaled < MINV) begin
      dout = MINV[OUT_W-1:0];
    end else begin
      dout = scaled[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/sinc4_decimator.sv
module sinc4_decimator
  import sinc4_pkg::*;
#(
  parameter int DEC_LOG2 = 11,
  parameter int OUT_W    = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_single,
  input  logic             clr_req,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word
);

  localparam int ORDER  = SINC_ORDER;
  localparam int ACC_W  = acc_width(DEC_LOG2, ORDER);
  localparam int SHIFT  = ORDER * DEC_LOG2 - (OUT_W - 1);
  localparam int PH_W   = DEC_LOG2;
  localparam int SET_W  = settle_width(ORDER);
  localparam logic [SET_W-1:0] SETTLE = SET_W'(ORDER - 1);

  logic [PH_W-1:0]         phase_q;
  logic                    tick_q;
  logic [SET_W-1:0]        settle_q;
  logic                    settled;
  logic                    conv_done;
  logic                    clr_now;
  logic                    emit;
  logic signed [ACC_W-1:0] integ_out;
  logic signed [ACC_W-1:0] comb_out;
  logic [OUT_W-1:0]        fmt_out;
  logic                    out_valid_q;
  logic [OUT_W-1:0]        out_word_q;

  assign settled   = (settle_q == SETTLE);
  assign conv_done = tick_q && settled && mode_single;
  assign clr_now   = clr_req || conv_done;
  assign emit      = tick_q && settled && !clr_req;

  // Position within the current decimation period
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (clr_now) begin
      phase_q <= in_valid ? PH_W'(1) : '0;
    end else if (in_valid) begin
      phase_q <= phase_q + PH_W'(1);
    end
  end

  // Decimation point: the last sample of a period was taken at the previous edge
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= in_valid && (phase_q == '1) && !clr_now;
    end
  end

  // Decimation points seen since the last clear, saturating at ORDER-1
  always_ff @(posedge clk) begin
    if (rst) begin
      settle_q <= '0;
    end else if (clr_now) begin
      settle_q <= '0;
    end else if (tick_q && !settled) begin
      settle_q <= settle_q + SET_W'(1);
    end
  end

  sinc4_integ #(
    .ACC_W (ACC_W),
    .ORDER (ORDER)
  ) u_integ (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_now),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .acc_out  (integ_out)
  );

  sinc4_comb #(
    .ACC_W (ACC_W),
    .ORDER (ORDER)
  ) u_comb (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_now),
    .tick (tick_q),
    .din  (integ_out),
    .dout (comb_out)
  );

  sinc4_fmt #(
    .ACC_W (ACC_W),
    .OUT_W (OUT_W),
    .SHIFT (SHIFT)
  ) u_fmt (
    .din  (comb_out),
    .dout (fmt_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_word_q  <= '0;
    end else begin
      out_valid_q <= emit;
      if (emit) begin
        out_word_q <= fmt_out;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_word  = out_word_q;

endmodule

// File: rtl/sinc4_decimator_chk.sv
module sinc4_decimator_chk #(
  parameter int ORDER    = 4,
  parameter int SET_W    = 2,
  parameter int DEC_LOG2 = 11,
  parameter int OUT_W    = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                mode_single,
  input logic                clr_req,
  input logic                in_valid,
  input logic                out_valid,
  input logic [OUT_W-1:0]    out_word,
  input logic                tick_q,
  input logic [SET_W-1:0]    settle_q,
  input logic [DEC_LOG2-1:0] phase_q
);

  localparam logic [SET_W-1:0] FULL = SET_W'(ORDER - 1);

  // R1: reset leaves the outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_word == '0));

  // R5: a strobe is always preceded by a decimation point
  a_r5_strobe_after_tick: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(tick_q));

  // R6: a strobe needs a full settling count
  a_r6_settled_first: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(settle_q) == FULL));

  // R7: continuous mode keeps its state after a result
  a_r7_cont_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(mode_single)) |-> (settle_q == FULL));

  // R8: single-cycle mode wipes the state after its result
  a_r8_single_wipes: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(mode_single)) |-> (settle_q == '0));

  // R9: a clear request cancels the next strobe
  a_r9_clear_blocks: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> !out_valid);

  // R4: idle input cycles leave the sample phase alone
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clr_req) |=> $stable(phase_q));

endmodule

bind sinc4_decimator sinc4_decimator_chk #(
  .ORDER    (ORDER),
  .SET_W    (SET_W),
  .DEC_LOG2 (DEC_LOG2),
  .OUT_W    (OUT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_single (mode_single),
  .clr_req     (clr_req),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_word    (out_word),
  .tick_q      (tick_q),
  .settle_q    (settle_q),
  .phase_q     (phase_q)
);

// File: tb/sinc4_decimator_test.sv
module sinc4_decimator_test;

  localparam int L    = 6;
  localparam int R    = 1 << L;
  localparam int NH   = 4 * R - 3;
  localparam int SH   = 4 * L - 23;
  localparam int HMAX = 4096;
  localparam int QMAX = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_single = 1'b0;
  logic        clr_req = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic        out_valid;
  logic [23:0] out_word;

  always #4 clk = ~clk;

  sinc4_decimator #(.DEC_LOG2(L), .OUT_W(24)) uut (
    .clk         (clk),
    .rst         (rst),
    .mode_single (mode_single),
    .clr_req     (clr_req),
    .in_valid    (in_valid),
    .in_bit      (in_bit),
    .out_valid   (out_valid),
    .out_word    (out_word)
  );

  int          nchk = 0;
  int          nfail = 0;
  longint      hk [0:4*R-1];
  int          hist [0:HMAX-1];
  int          nh = 0;
  int          cnt = 0;
  bit          pend = 1'b0;
  logic [23:0] expq [0:QMAX-1];
  int          ne = 0;
  logic [23:0] outs [0:QMAX-1];
  int          no = 0;
  logic [15:0] lf = 16'hACE1;

  // Collect every result away from the active edge
  always @(negedge clk) begin
    if (out_valid && no < QMAX) begin
      outs[no] = out_word;
      no++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit rnd_bit();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  function automatic logic [23:0] fmt_exp(input longint y);
    longint q;
    if (SH > 0) q = (y + (longint'(1) <<< ((SH > 0) ? SH - 1 : 0))) >>> ((SH > 0) ? SH : 0);
    else        q = y <<< ((SH > 0) ? 0 : -SH);
    if (q > 64'sd8388607)  q = 64'sd8388607;
    if (q < -64'sd8388608) q = -64'sd8388608;
    return q[23:0];
  endfunction

  function automatic logic [23:0] model_out();
    longint y = 0;
    for (int k = 0; k < NH; k++) begin
      if (nh - 1 - k >= 0) y += hk[k] * longint'(hist[nh - 1 - k]);
    end
    return fmt_exp(y);
  endfunction

  // One sample in one cycle, optionally together with a clear request
  task automatic send(input bit b, input bit clr);
    in_valid = 1'b1;
    in_bit   = b;
    clr_req  = clr;
    if (clr) begin
      if (pend) ne--;
      nh = 0;
      cnt = 0;
    end
    pend = 1'b0;
    hist[nh] = b ? 1 : -1;
    nh++;
    cnt++;
    if (mode_single) begin
      if (cnt == 4 * R) begin
        expq[ne] = model_out();
        ne++;
        pend = 1'b1;
        nh = 0;
        cnt = 0;
      end
    end else if (cnt % R == 0 && cnt >= 4 * R) begin
      expq[ne] = model_out();
      ne++;
      pend = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    clr_req  = 1'b0;
  endtask

  task automatic idle(input int n);
    pend = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clr_req  = 1'b1;
    in_valid = 1'b0;
    if (pend) ne--;
    pend = 1'b0;
    nh = 0;
    cnt = 0;
    @(negedge clk);
    clr_req = 1'b0;
  endtask

  task automatic check_range(input int nb, input int eb, input string req);
    chk((no - nb) == (ne - eb), req, no - nb, ne - eb);
    for (int i = 0; i < ne - eb && i < no - nb; i++) begin
      chk(outs[nb + i] == expq[eb + i], req, outs[nb + i], expq[eb + i]);
    end
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(out_word == 24'h0, "R1", out_word, 0);
  endtask

  task automatic t_const(input bit b);
    int nb;
    int eb;
    mode_single = 1'b0;
    do_clear();
    nb = no;
    eb = ne;
    for (int i = 0; i < 3 * R; i++) send(b, 1'b0);
    idle(4);
    chk(no == nb, "R6", no - nb, 0);
    for (int i = 0; i < R; i++) send(b, 1'b0);
    idle(4);
    chk(no == nb + 1, "R6", no - nb, 1);
    chk(outs[nb] == (b ? 24'h7FFFFF : 24'h800000), "R2", outs[nb], b ? 24'h7FFFFF : 24'h800000);
    for (int i = 0; i < R; i++) send(b, 1'b0);
    idle(4);
    chk(no == nb + 2, "R7", no - nb, 2);
    check_range(nb, eb, "R2");
  endtask

  task automatic t_alternating();
    int nb;
    int eb;
    mode_single = 1'b0;
    do_clear();
    nb = no;
    eb = ne;
    for (int i = 0; i < 6 * R; i++) send(i[0], 1'b0);
    idle(4);
    check_range(nb, eb, "R3");
  endtask

  task automatic t_random_gaps();
    int nb;
    int eb;
    mode_single = 1'b0;
    do_clear();
    nb = no;
    eb = ne;
    for (int i = 0; i < 8 * R; i++) begin
      send(rnd_bit(), 1'b0);
      if (lf[3:2] == 2'b00) idle(1 + int'(lf[5:4]));
    end
    idle(4);
    chk((no - nb) == 5, "R4", no - nb, 5);
    check_range(nb, eb, "R3");
  endtask

  task automatic t_latency();
    int nb;
    int eb;
    mode_single = 1'b0;
    do_clear();
    nb = no;
    eb = ne;
    for (int i = 0; i < 4 * R - 1; i++) send(rnd_bit(), 1'b0);
    send(rnd_bit(), 1'b0);
    chk(out_valid == 1'b0, "R5", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R5", out_valid, 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5", out_valid, 0);
    idle(2);
    check_range(nb, eb, "R5");
  endtask

  task automatic t_single_gapped();
    int nb;
    int eb;
    mode_single = 1'b1;
    do_clear();
    nb = no;
    eb = ne;
    for (int c = 0; c < 3; c++) begin
      for (int i = 0; i < 4 * R; i++) send(rnd_bit(), 1'b0);
      idle(6);
    end
    chk((no - nb) == 3, "R8", no - nb, 3);
    for (int i = 0; i < 3 * R; i++) send(1'b1, 1'b0);
    idle(6);
    chk((no - nb) == 3, "R6", no - nb, 3);
    check_range(nb, eb, "R8");
  endtask

  task automatic t_single_b2b();
    int nb;
    int eb;
    mode_single = 1'b1;
    do_clear();
    nb = no;
    eb = ne;
    for (int i = 0; i < 12 * R; i++) send(rnd_bit(), 1'b0);
    idle(6);
    chk((no - nb) == 3, "R8", no - nb, 3);
    check_range(nb, eb, "R8");
  endtask

  task automatic t_clear_mid();
    int nb;
    int eb;
    mode_single = 1'b0;
    do_clear();
    nb = no;
    eb = ne;
    for (int i = 0; i < 5 * R; i++) send(rnd_bit(), 1'b0);
    do_clear();
    idle(4);
    chk((no - nb) == 1, "R9", no - nb, 1);
    for (int i = 0; i < R + 5; i++) send(rnd_bit(), 1'b0);
    send(rnd_bit(), 1'b1);
    for (int i = 0; i < 4 * R - 1; i++) send(rnd_bit(), 1'b0);
    idle(4);
    chk((no - nb) == 2, "R9", no - nb, 2);
    check_range(nb, eb, "R9");
  endtask

  initial begin
    longint a [0:4*R-1];
    longint b [0:4*R-1];
    for (int i = 0; i < 4 * R; i++) a[i] = (i < R) ? 1 : 0;
    for (int st = 1; st < 4; st++) begin
      for (int i = 0; i < 4 * R; i++) begin
        b[i] = 0;
        for (int j = 0; j < R; j++) begin
          if (i - j >= 0) b[i] += a[i - j];
        end
      end
      for (int i = 0; i < 4 * R; i++) a[i] = b[i];
    end
    for (int i = 0; i < 4 * R; i++) hk[i] = a[i];

    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_const(1'b1);
    t_const(1'b0);
    t_alternating();
    t_random_gaps();
    t_latency();
    t_single_gapped();
    t_single_b2b();
    t_clear_mid();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule